// File: doc/BRIEF.md
# Cache Maintenance Command Decoder

This block sits between the core's coprocessor write port for cache maintenance and the controllers that carry out the work. It receives one transaction at a time, made of a 4-bit secondary register selector, a 3-bit operation selector and a 32-bit data word. The selector pair alone chooses the operation. The block turns each supported pair into a one-hot command for the instruction-cache controller, the data-cache controller, or both. Single-line commands carry the data word as an address or a set/way index. Whole-cache commands carry zero.

Two encodings create no cache command and block the core instead. The drain encoding holds the core until the write buffer reports empty. The wait encoding holds the core in a low-power state until the wake input is seen. Any pair outside the map is flagged as unsupported, and so is any read of the register. A read returns zero. An unsupported transaction issues nothing.

The core must not present a new transaction while `stall` is high. Any transaction presented then is dropped.

Top module: `cmaint_top`

## Requirements
- R1: A synchronous reset clears every pending command, `stall`, `lowPower` and `badReq`. After reset both valid outputs are 0 and both command buses read 0.
- R2: Whole-cache invalidates, with the operand driven as 0 whatever the data word holds:
  - Pair (7,0) raises both valids, with `icCmd`=3'b001 and `dcCmd`=6'b000001.
  - Pair (5,0) sends only `icCmd`=3'b001.
  - Pair (6,0) sends only `dcCmd`=6'b000001.
  - When both caches are targeted, each valid drops on its own acceptance, and `stall` stays high until both have been accepted.
- R3: Instruction-cache line operations by address carry the data word unchanged on `icAddr`:
  - Pair (5,1) sends `icCmd`=3'b010 (invalidate line).
  - Pair (13,1) sends `icCmd`=3'b100 (prefetch line).
- R4: Data-cache line operations by address carry the data word on `dcOperand`:
  - Pair (6,1) sends `dcCmd`=6'b000010 (invalidate).
  - Pair (10,1) sends 6'b000100 (clean).
  - Pair (14,1) sends 6'b001000 (clean and invalidate).
- R5: Data-cache line operations by set/way index carry the data word on `dcOperand`:
  - Pair (10,2) sends `dcCmd`=6'b010000 (clean).
  - Pair (14,2) sends 6'b100000 (clean and invalidate).
- R6: Handshake and `stall` for commands:
  - A command appears in the cycle after its transaction is accepted.
  - The command and its operand stay stable until the target's ready is seen, and `stall` stays high during that time.
  - Valid drops, and `stall` falls, in the cycle after acceptance.
- R7: Pair (10,4) issues no command and holds `stall` high until `wbEmpty` is seen. If `wbEmpty` is already high, `stall` lasts exactly one cycle.
- R8: Pair (0,4) issues no command and holds `stall` and `lowPower` high until `irqWake` is seen. If `irqWake` is already high, both last exactly one cycle.
- R9: Any other write pair raises `badReq` for exactly one cycle, in the cycle after acceptance. It issues no command and does not raise `stall`.
- R10: A read transaction raises `badReq` for one cycle, issues nothing, and sees `rdData` = 0.
- R11: A transaction presented while `stall` is high is dropped. It creates no command and no `badReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Transaction present; taken when `stall` is low |
| reqRead | input | 1 | 1 = read of the register, 0 = write |
| reqCrm | input | 4 | Secondary register selector |
| reqOp2 | input | 3 | Operation selector |
| reqData | input | DATA_W | Data word (address or index) |
| rdData | output | DATA_W | Read return data, always zero |
| badReq | output | 1 | One-cycle unsupported-transaction flag |
| stall | output | 1 | Holds the core |
| lowPower | output | 1 | Low-power indication during the wait operation |
| icValid | output | 1 | Instruction-cache command valid |
| icCmd | output | 3 | One-hot instruction-cache command |
| icAddr | output | DATA_W | Instruction-cache operand |
| icReady | input | 1 | Instruction-cache controller accepts |
| dcValid | output | 1 | Data-cache command valid |
| dcCmd | output | 6 | One-hot data-cache command |
| dcOperand | output | DATA_W | Data-cache address or index operand |
| dcReady | input | 1 | Data-cache controller accepts |
| wbEmpty | input | 1 | Write buffer is empty |
| irqWake | input | 1 | Interrupt wake input |

## Verification
Every result is registered once. Commands, `stall`, `lowPower` and `badReq` all change in the cycle after the clock edge that accepts the transaction. They clear in the cycle after the edge that sees ready, `wbEmpty` or `irqWake`.

The bench drives inputs on falling edges. It takes each reading at the falling edge that follows the edge in question, which puts every sample half a cycle after the change. Single-cycle results, such as the one-cycle `stall` of an already-empty drain and the `badReq` pulse, are checked both at that falling edge and one cycle later, so the check confirms the exact length of each pulse.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
  localparam int CRM_W  = 4;
  localparam int OP2_W  = 3;
  localparam int IC_OPS = 3;   // bit0 inv all, bit1 inv line, bit2 prefetch line
  localparam int DC_OPS = 6;   // bit0 inv all, 1 inv line, 2 clean line, 3 clean+inv line, 4 clean idx, 5 clean+inv idx

  typedef struct packed {
    logic [IC_OPS-1:0] ic;
    logic [DC_OPS-1:0] dc;
    logic              drain;
    logic              wfi;
    logic              takesData;
    logic              bad;
  } decodeT;

  typedef struct packed {
    logic issue;     // accepted supported write: load command registers
    logic flagErr;   // accepted unsupported write or read
  } strobeT;

  function automatic decodeT decodeOp(input logic [CRM_W-1:0] crm,
                                      input logic [OP2_W-1:0] op2);
    decodeT d;
    d = '0;
    case ({crm, op2})
      {4'd7,  3'd0}: begin d.ic = 3'b001; d.dc = 6'b000001; end
      {4'd5,  3'd0}: d.ic = 3'b001;
      {4'd6,  3'd0}: d.dc = 6'b000001;
      {4'd5,  3'd1}: begin d.ic = 3'b010; d.takesData = 1'b1; end
      {4'd13, 3'd1}: begin d.ic = 3'b100; d.takesData = 1'b1; end
      {4'd6,  3'd1}: begin d.dc = 6'b000010; d.takesData = 1'b1; end
      {4'd10, 3'd1}: begin d.dc = 6'b000100; d.takesData = 1'b1; end
      {4'd14, 3'd1}: begin d.dc = 6'b001000; d.takesData = 1'b1; end
      {4'd10, 3'd2}: begin d.dc = 6'b010000; d.takesData = 1'b1; end
      {4'd14, 3'd2}: begin d.dc = 6'b100000; d.takesData = 1'b1; end
      {4'd10, 3'd4}: d.drain = 1'b1;
      {4'd0,  3'd4}: d.wfi = 1'b1;
      default:       d.bad = 1'b1;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqRead,
  input  logic   decIc,
  input  logic   decDc,
  input  logic   decDrain,
  input  logic   decWfi,
  input  logic   decBad,
  input  logic   icReady,
  input  logic   dcReady,
  input  logic   wbEmpty,
  input  logic   irqWake,
  output logic   icPend,
  output logic   dcPend,
  output logic   stall,
  output logic   lowPower,
  output strobeT strb
);
  logic icPendQ, dcPendQ, drainQ, wfiQ;
  logic busy, accept, isCmd;

  assign busy   = icPendQ | dcPendQ | drainQ | wfiQ;
  assign accept = reqValid && !busy;
  assign isCmd  = accept && !reqRead && !decBad;

  always_comb begin
    strb.issue   = isCmd;
    strb.flagErr = accept && (reqRead || decBad);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icPendQ <= 1'b0;
      dcPendQ <= 1'b0;
      drainQ  <= 1'b0;
      wfiQ    <= 1'b0;
    end else if (isCmd) begin
      icPendQ <= decIc;
      dcPendQ <= decDc;
      drainQ  <= decDrain;
      wfiQ    <= decWfi;
    end else begin
      icPendQ <= icPendQ && !icReady;
      dcPendQ <= dcPendQ && !dcReady;
      drainQ  <= drainQ && !wbEmpty;
      wfiQ    <= wfiQ && !irqWake;
    end
  end

  assign icPend   = icPendQ;
  assign dcPend   = dcPendQ;
  assign stall    = busy;
  assign lowPower = wfiQ;
endmodule

// File: rtl/cmaint_dp.sv
module cmaint_dp
  import cmaint_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [IC_OPS-1:0] decIc,
  input  logic [DC_OPS-1:0] decDc,
  input  logic              decTakesData,
  input  logic [DATA_W-1:0] reqData,
  input  logic              icPend,
  input  logic              dcPend,
  output logic [IC_OPS-1:0] icCmd,
  output logic [DC_OPS-1:0] dcCmd,
  output logic [DATA_W-1:0] operand,
  output logic              badReq
);
  logic [IC_OPS-1:0] icCmdQ;
  logic [DC_OPS-1:0] dcCmdQ;
  logic [DATA_W-1:0] operandQ;
  logic              errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      icCmdQ   <= '0;
      dcCmdQ   <= '0;
      operandQ <= '0;
      errQ     <= 1'b0;
    end else begin
      errQ <= strb.flagErr;
      if (strb.issue) begin
        icCmdQ   <= decIc;
        dcCmdQ   <= decDc;
        operandQ <= decTakesData ? reqData : '0;
      end
    end
  end

  assign icCmd   = icPend ? icCmdQ : '0;
  assign dcCmd   = dcPend ? dcCmdQ : '0;
  assign operand = operandQ;
  assign badReq  = errQ;
endmodule

// File: rtl/cmaint_top.sv
module cmaint_top
  import cmaint_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [CRM_W-1:0]  reqCrm,
  input  logic [OP2_W-1:0]  reqOp2,
  input  logic [DATA_W-1:0] reqData,
  output logic [DATA_W-1:0] rdData,
  output logic              badReq,
  output logic              stall,
  output logic              lowPower,
  output logic              icValid,
  output logic [IC_OPS-1:0] icCmd,
  output logic [DATA_W-1:0] icAddr,
  input  logic              icReady,
  output logic              dcValid,
  output logic [DC_OPS-1:0] dcCmd,
  output logic [DATA_W-1:0] dcOperand,
  input  logic              dcReady,
  input  logic              wbEmpty,
  input  logic              irqWake
);
  decodeT            dec;
  strobeT            strb;
  logic              icPend, dcPend;
  logic [DATA_W-1:0] operand;

  assign dec = decodeOp(reqCrm, reqOp2);

  cmaint_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqRead  (reqRead),
    .decIc    (|dec.ic),
    .decDc    (|dec.dc),
    .decDrain (dec.drain),
    .decWfi   (dec.wfi),
    .decBad   (dec.bad),
    .icReady  (icReady),
    .dcReady  (dcReady),
    .wbEmpty  (wbEmpty),
    .irqWake  (irqWake),
    .icPend   (icPend),
    .dcPend   (dcPend),
    .stall    (stall),
    .lowPower (lowPower),
    .strb     (strb)
  );

  cmaint_dp #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .decIc        (dec.ic),
    .decDc        (dec.dc),
    .decTakesData (dec.takesData),
    .reqData      (reqData),
    .icPend       (icPend),
    .dcPend       (dcPend),
    .icCmd        (icCmd),
    .dcCmd        (dcCmd),
    .operand      (operand),
    .badReq       (badReq)
  );

  assign icValid   = icPend;
  assign dcValid   = dcPend;
  assign icAddr    = operand;
  assign dcOperand = operand;
  assign rdData    = '0;
endmodule

// File: rtl/cmaint_chk.sv
module cmaint_chk
  import cmaint_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              lowPower,
  input logic              irqWake,
  input logic              badReq,
  input logic              icValid,
  input logic              icReady,
  input logic [IC_OPS-1:0] icCmd,
  input logic [DATA_W-1:0] icAddr,
  input logic              dcValid,
  input logic              dcReady,
  input logic [DC_OPS-1:0] dcCmd,
  input logic [DATA_W-1:0] dcOperand
);
  // R6
  ic_hold_chk: assert property (@(posedge clk) disable iff (rst)
    icValid && !icReady |=> icValid && $stable(icCmd) && $stable(icAddr));
  // R6
  dc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dcValid && !dcReady |=> dcValid && $stable(dcCmd) && $stable(dcOperand));
  // R6
  cmd_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (icValid || dcValid) |-> stall);
  // R3
  ic_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    icValid |-> $countones(icCmd) == 1);
  // R4
  dc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    dcValid |-> $countones(dcCmd) == 1);
  // R9
  bad_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    badReq |-> !icValid && !dcValid && !stall);
  // R8
  sleep_stall_chk: assert property (@(posedge clk) disable iff (rst)
    lowPower |-> stall);
  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lowPower && !irqWake |=> lowPower);
endmodule

bind cmaint_top cmaint_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .lowPower  (lowPower),
  .irqWake   (irqWake),
  .badReq    (badReq),
  .icValid   (icValid),
  .icReady   (icReady),
  .icCmd     (icCmd),
  .icAddr    (icAddr),
  .dcValid   (dcValid),
  .dcReady   (dcReady),
  .dcCmd     (dcCmd),
  .dcOperand (dcOperand)
);

// File: tb/cmaint_top_test.sv
module cmaint_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqRead = 1'b0;
  logic [3:0]  reqCrm = '0;
  logic [2:0]  reqOp2 = '0;
  logic [31:0] reqData = '0;
  logic [31:0] rdData, icAddr, dcOperand;
  logic        badReq, stall, lowPower, icValid, dcValid;
  logic [2:0]  icCmd;
  logic [5:0]  dcCmd;
  logic        icReady = 1'b0, dcReady = 1'b0, wbEmpty = 1'b0, irqWake = 1'b0;
  int          total = 0, failed = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cmaint_top uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqRead(reqRead),
    .reqCrm(reqCrm), .reqOp2(reqOp2), .reqData(reqData), .rdData(rdData),
    .badReq(badReq), .stall(stall), .lowPower(lowPower),
    .icValid(icValid), .icCmd(icCmd), .icAddr(icAddr), .icReady(icReady),
    .dcValid(dcValid), .dcCmd(dcCmd), .dcOperand(dcOperand), .dcReady(dcReady),
    .wbEmpty(wbEmpty), .irqWake(irqWake)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rd, input logic [3:0] crm, input logic [2:0] op2,
                       input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqCrm = crm; reqOp2 = op2; reqData = d;
    @(negedge clk);
    reqValid = 1'b0; reqRead = 1'b0; reqData = '0;
  endtask

  task automatic pulseReady(input logic ic, input logic dc);
    icReady = ic; dcReady = dc;
    @(negedge clk);
    icReady = 1'b0; dcReady = 1'b0;
  endtask

  task automatic testReset;
    check("R1 stall", stall, 0);
    check("R1 lowPower", lowPower, 0);
    check("R1 valids", {icValid, dcValid, badReq}, 0);
    check("R1 cmds", {icCmd, dcCmd}, 0);
  endtask

  task automatic testWhole;
    issue(0, 4'd7, 3'd0, 32'hDEADBEEF);
    check("R2 both valid", {icValid, dcValid, stall}, 3'b111);
    check("R2 both cmd", {icCmd, dcCmd}, {3'b001, 6'b000001});
    check("R2 operand zero", {icAddr, dcOperand}, 0);
    pulseReady(1, 0);
    check("R2 ic done dc held", {icValid, dcValid, stall}, 3'b011);
    pulseReady(0, 1);
    check("R2 both done", {icValid, dcValid, stall}, 3'b000);
    issue(0, 4'd5, 3'd0, 32'h1234);
    check("R2 ic inv all", {icValid, dcValid, icCmd, icAddr}, {2'b10, 3'b001, 32'h0});
    pulseReady(1, 0);
    issue(0, 4'd6, 3'd0, 32'h5678);
    check("R2 dc inv all", {icValid, dcValid, dcCmd, dcOperand}, {2'b01, 6'b000001, 32'h0});
    pulseReady(0, 1);
  endtask

  task automatic testIcLine;
    issue(0, 4'd5, 3'd1, 32'hA0A0_0040);
    check("R3 ic inv line", {icValid, icCmd, icAddr}, {1'b1, 3'b010, 32'hA0A0_0040});
    repeat (3) @(negedge clk);
    check("R6 held", {icValid, stall, icCmd, icAddr}, {2'b11, 3'b010, 32'hA0A0_0040});
    pulseReady(1, 0);
    check("R6 released", {icValid, stall}, 0);
    issue(0, 4'd13, 3'd1, 32'h0000_8020);
    check("R3 prefetch", {icValid, dcValid, icCmd, icAddr}, {2'b10, 3'b100, 32'h0000_8020});
    pulseReady(1, 0);
  endtask

  task automatic testDcLine;
    logic [3:0] crms [5] = '{4'd6, 4'd10, 4'd14, 4'd10, 4'd14};
    logic [2:0] ops  [5] = '{3'd1, 3'd1, 3'd1, 3'd2, 3'd2};
    for (int i = 0; i < 5; i++) begin
      issue(0, crms[i], ops[i], 32'hC000_0000 + i);
      check(i < 3 ? "R4 dc addr op" : "R5 dc index op",
            {icValid, dcValid, dcCmd, dcOperand},
            {2'b01, 6'b000010 << i, 32'hC000_0000 + i});
      pulseReady(0, 1);
      check("R6 dc released", {dcValid, stall}, 0);
    end
  endtask

  task automatic testDrain;
    wbEmpty = 1'b0;
    issue(0, 4'd10, 3'd4, 32'h0);
    check("R7 drain stall", {stall, icValid, dcValid}, 3'b100);
    repeat (2) @(negedge clk);
    check("R7 drain waits", stall, 1);
    wbEmpty = 1'b1;
    @(negedge clk);
    check("R7 drain ends", stall, 0);
    issue(0, 4'd10, 3'd4, 32'h0);
    check("R7 empty one cycle a", stall, 1);
    @(negedge clk);
    check("R7 empty one cycle b", stall, 0);
  endtask

  task automatic testWfi;
    irqWake = 1'b0;
    issue(0, 4'd0, 3'd4, 32'h0);
    check("R8 sleep", {stall, lowPower, icValid, dcValid}, 4'b1100);
    repeat (3) @(negedge clk);
    check("R8 sleep held", {stall, lowPower}, 2'b11);
    irqWake = 1'b1;
    @(negedge clk);
    check("R8 wake", {stall, lowPower}, 0);
    issue(0, 4'd0, 3'd4, 32'h0);
    check("R8 pending a", {stall, lowPower}, 2'b11);
    @(negedge clk);
    check("R8 pending b", {stall, lowPower}, 0);
    irqWake = 1'b0;
  endtask

  task automatic testBad;
    logic [3:0] crms [4] = '{4'd10, 4'd7, 4'd15, 4'd0};
    logic [2:0] ops  [4] = '{3'd3, 3'd1, 3'd0, 3'd0};
    for (int i = 0; i < 4; i++) begin
      issue(0, crms[i], ops[i], 32'hFFFF_FFFF);
      check("R9 flagged", {badReq, stall, icValid, dcValid}, 4'b1000);
      @(negedge clk);
      check("R9 one cycle", badReq, 0);
    end
  endtask

  task automatic testRead;
    issue(1, 4'd5, 3'd0, 32'h0);
    check("R10 read", {badReq, stall, icValid, dcValid}, 4'b1000);
    check("R10 rdData", rdData, 0);
  endtask

  task automatic testIgnore;
    wbEmpty = 1'b0;
    issue(0, 4'd10, 3'd4, 32'h0);
    issue(0, 4'd5, 3'd0, 32'h0);
    check("R11 no cmd while stalled", {icValid, badReq}, 0);
    issue(0, 4'd15, 3'd7, 32'h0);
    check("R11 no flag while stalled", badReq, 0);
    wbEmpty = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 dropped", {stall, icValid, dcValid}, 0);
  endtask

  task automatic testMidReset;
    irqWake = 1'b0;
    issue(0, 4'd0, 3'd4, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears sleep", {stall, lowPower}, 0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testWhole();
    testIcLine();
    testDcLine();
    testDrain();
    testWfi();
    testBad();
    testRead();
    testIgnore();
    testMidReset();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end
endmodule